// File: doc/BRIEF.md
# Latched serial-to-parallel shift register

This block turns a serial bit stream into a parallel word. Bits enter a chain of shift stages one at a time. A separate transfer strobe copies the whole chain into a holding register, and that register drives the parallel outputs. Because shifting and transfer are decoupled, a new word can be assembled while the previous one is still on the outputs. The last stage of the chain is brought out as a cascade output, so several units can be chained into a longer register.

The shift and transfer strobes are slow external levels. Each one passes through a synchronizer into the system clock domain, and a rising level becomes a single-cycle pulse. An active-low clear empties the shift chain at once and leaves the holding register alone. An active-low output enable either drives the parallel pins from the holding register or floats them. A companion valid flag reports which of the two is in effect, so logic downstream never has to look at high-impedance values.

Top module: `latched_sipo`

## Requirements
- R1: A rising edge on `shift_stb` produces exactly one shift: stage 0 takes `ser_in` and every stage k takes the old value of stage k-1.
- R2: A rising edge on `xfer_stb` copies every shift stage into the holding register. Without a transfer, the holding register keeps its value however many shifts occur.
- R3: `ser_out` always equals the last shift stage, so after a shift it shows the old value of the second-to-last stage.
- R4: When `clr_n` is low, all shift stages and `ser_out` go to 0 without waiting for a clock edge, and the holding register is unchanged.
- R5: A transfer that follows a clear drives all parallel outputs to 0.
- R6: While `oe_n` is 0, `par_q` equals the holding register and `par_valid` is 1. While `oe_n` is 1, every `par_q` bit is high-impedance and `par_valid` is 0. Toggling `oe_n` does not change the holding register.
- R7: When both strobes rise together, the holding register captures the chain as it was before that shift, so the outputs trail the chain by one shift.
- R8: Output bit 0 corresponds to stage 0. A byte shifted in most-significant bit first therefore appears unchanged on `par_q` after a transfer.
- R9: A strobe held high for any number of cycles counts as one edge. Its effect becomes visible on the third system clock edge after the strobe rises.
- R10: Shift edges that occur while `clr_n` is low are ignored. The first shift edge after `clr_n` is released shifts normally.
- R11: When the `ser_out` of one unit feeds the `ser_in` of the next and the strobes are shared, the two units behave as a single register twice as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| clr_n | input | 1 | Active-low asynchronous clear of the shift chain only |
| ser_in | input | 1 | Serial data into stage 0 |
| shift_stb | input | 1 | Shift strobe; the rising edge is used |
| xfer_stb | input | 1 | Transfer strobe; the rising edge is used |
| oe_n | input | 1 | Active-low parallel output enable |
| ser_out | output | 1 | Cascade output, the last shift stage |
| par_q | output | WIDTH | Parallel outputs, high-impedance when disabled |
| par_valid | output | 1 | 1 when `par_q` is driven |

## Verification
The assertions assume three things about the inputs. Each strobe stays high and then low for at least SYNC_STAGES+1 clock cycles, so that every edge is seen once. `ser_in` is stable while a shift pulse is in flight. `clr_n` changes only away from the clock edge, and it is not released while a shift edge is still in the synchronizer. The bench meets all three: it drives every input at the falling clock edge, holds each strobe level for at least four cycles, and keeps `ser_in` fixed for the whole of each operation. Random operations (shift, transfer, coincident strobes, clear, enable toggle) run through two chained units and are compared with a model of both.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   // smallest synchronizer depth that is allowed
   localparam int unsigned MIN_SYNC = 2;

   // single-cycle requests produced from the two strobes
   typedef struct packed {
      logic shift;
      logic xfer;
   } stb_pulse_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_in,
   output logic pulse
);
   import sipo_pkg::*;

   if (SYNC_STAGES < MIN_SYNC) begin : g_bad_depth
      $error("strobe_sync: SYNC_STAGES below minimum");
   end

   // pipe[SYNC_STAGES-1] is the synchronized level, pipe[SYNC_STAGES] its delayed copy
   logic [SYNC_STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= 1'b0;
      else        pipe[0] <= stb_in;
   end

   for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[i] <= 1'b0;
         else        pipe[i] <= pipe[i-1];
      end
   end

   assign pulse = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

   // R9: a detected edge lasts exactly one cycle
   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             shift,
   input  logic             din,
   output logic [WIDTH-1:0] stages,
   output logic             dout
);
   if (WIDTH < 2) begin : g_bad_width
      $error("shift_chain: WIDTH must be at least 2");
   end

   logic wipe_n;
   assign wipe_n = rst_n & clr_n;

   always_ff @(posedge clk or negedge wipe_n) begin
      if (!wipe_n)    stages[0] <= 1'b0;
      else if (shift) stages[0] <= din;
   end

   for (genvar k = 1; k < WIDTH; k++) begin : g_stage
      always_ff @(posedge clk or negedge wipe_n) begin
         if (!wipe_n)    stages[k] <= 1'b0;
         else if (shift) stages[k] <= stages[k-1];
      end
   end

   assign dout = stages[WIDTH-1];

   // R4: clear holds the whole chain at zero
   p_clear_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (stages == '0 && dout == 1'b0));

   // R1: stage 0 takes the serial input on a shift
   p_shift_in_r1: assert property (@(posedge clk) disable iff (!wipe_n)
      shift |=> stages[0] == $past(din));

   // R1: with no shift the chain is frozen
   p_frozen_r1: assert property (@(posedge clk) disable iff (!wipe_n)
      !shift |=> $stable(stages));

   // R3: cascade output shows the old second-to-last stage after a shift
   p_cascade_r3: assert property (@(posedge clk) disable iff (!wipe_n)
      shift |=> dout == $past(stages[WIDTH-2]));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end

   // R2: a load captures the presented word
   p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(din));

   // R2: without a load the word is kept
   p_keep_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             ser_in,
   input  logic             shift_stb,
   input  logic             xfer_stb,
   input  logic             oe_n,
   output logic             ser_out,
   output logic [WIDTH-1:0] par_q,
   output logic             par_valid
);
   import sipo_pkg::*;

   stb_pulse_t       req;
   logic [WIDTH-1:0] chain_q;
   logic [WIDTH-1:0] hold_q;

   strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_shift_sync (
      .clk(clk), .rst_n(rst_n), .stb_in(shift_stb), .pulse(req.shift));

   strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_xfer_sync (
      .clk(clk), .rst_n(rst_n), .stb_in(xfer_stb), .pulse(req.xfer));

   shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .shift(req.shift),
      .din(ser_in), .stages(chain_q), .dout(ser_out));

   hold_reg #(.WIDTH(WIDTH)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(req.xfer), .din(chain_q), .q(hold_q));

   // tri-state drive kept at this wrapper only
   assign par_q     = oe_n ? {WIDTH{1'bz}} : hold_q;
   assign par_valid = ~oe_n;

   // R6: enabled pins present the holding register
   p_drive_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (par_q == hold_q && par_valid));

   // R7: coincident strobes capture the pre-shift chain
   p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req.shift && req.xfer) |=> hold_q == $past(chain_q));

   // R4: clear alone leaves the holding register intact
   p_clear_keeps_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n && !req.xfer) |=> $stable(hold_q));
endmodule

// File: tb/tb_latched_sipo.sv
module tb_latched_sipo;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic clk = 1'b0;
   logic rst_n, clr_n, ser_in, shift_stb, xfer_stb, oe_n;
   logic ser_out, ser_out_b, par_valid, par_valid_b;
   logic [W-1:0] par_q, par_q_b;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state: a = upstream unit, b = downstream unit
   logic [W-1:0] mc_a, mc_b, mh_a, mh_b;

   always #(CLK_P/2) clk = ~clk;

   latched_sipo #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(ser_in),
      .shift_stb(shift_stb), .xfer_stb(xfer_stb), .oe_n(oe_n),
      .ser_out(ser_out), .par_q(par_q), .par_valid(par_valid));

   latched_sipo #(.WIDTH(W)) dut_nxt (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(ser_out),
      .shift_stb(shift_stb), .xfer_stb(xfer_stb), .oe_n(oe_n),
      .ser_out(ser_out_b), .par_q(par_q_b), .par_valid(par_valid_b));

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // model operations
   function automatic void m_shift(input logic b);
      mc_b = {mc_b[W-2:0], mc_a[W-1]};
      mc_a = {mc_a[W-2:0], b};
   endfunction

   function automatic void m_xfer();
      mh_a = mc_a;
      mh_b = mc_b;
   endfunction

   // drive strobes high together, hold, then low
   task automatic strobe(input bit sh, input bit xf, input int hold_cycles);
      shift_stb = sh;
      xfer_stb  = xf;
      wait_edges(hold_cycles);
      shift_stb = 1'b0;
      xfer_stb  = 1'b0;
      wait_edges(4);
   endtask

   task automatic compare_all(input string req);
      check({req, " ser_out a"}, {7'd0, ser_out}, {7'd0, mc_a[W-1]});
      check({req, " ser_out b"}, {7'd0, ser_out_b}, {7'd0, mc_b[W-1]});
      if (!oe_n) begin
         check({req, " par_q a"}, par_q, mh_a);
         check({req, " par_q b"}, par_q_b, mh_b);
         check({req, " valid"}, {7'd0, par_valid}, 8'd1);
      end else begin
         check({req, " hiZ a"}, par_q, {W{1'bz}});
         check({req, " valid"}, {7'd0, par_valid}, 8'd0);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] byte_v;
      logic [15:0] word_v;
      int unsigned seed_v;
      rst_n = 0; clr_n = 1; ser_in = 0; shift_stb = 0; xfer_stb = 0; oe_n = 0;
      mc_a = '0; mc_b = '0; mh_a = '0; mh_b = '0;
      seed_v = $urandom(32'd4242);
      wait_edges(3);
      rst_n = 1;
      wait_edges(2);
      compare_all("R6 reset");

      // R8 / R2: byte shifted MSB first, outputs unchanged until transfer
      byte_v = 8'hA5;
      for (int i = W-1; i >= 0; i--) begin
         ser_in = byte_v[i];
         strobe(1, 0, 4);
         m_shift(byte_v[i]);
         check("R2 no change before transfer", par_q, 8'h00);
      end
      check("R1 chain msb at cascade", {7'd0, ser_out}, {7'd0, byte_v[7]});
      strobe(0, 1, 4);
      m_xfer();
      check("R8 byte on par_q", par_q, 8'hA5);
      compare_all("R2 transfer");

      // R9: long strobe counts once, visible on third edge
      ser_in = 1'b1;
      shift_stb = 1'b1;
      wait_edges(2);
      check("R9 not yet at edge 2", {7'd0, ser_out}, {7'd0, mc_a[W-1]});
      wait_edges(1);
      m_shift(1'b1);
      check("R9 shifted at edge 3", {7'd0, ser_out}, {7'd0, mc_a[W-1]});
      wait_edges(20);
      shift_stb = 1'b0;
      wait_edges(4);
      compare_all("R9 single shift");
      strobe(0, 1, 4);
      m_xfer();
      compare_all("R9 transfer after long strobe");

      // R7: coincident strobes give the pre-shift word
      ser_in = 1'b0;
      byte_v = mc_a;
      strobe(1, 1, 4);
      m_xfer();
      m_shift(1'b0);
      check("R7 lag by one shift", par_q, byte_v);
      compare_all("R7 coincide");

      // R6: disabled pins float and contents survive
      oe_n = 1'b1;
      wait_edges(2);
      compare_all("R6 disabled");
      oe_n = 1'b0;
      wait_edges(1);
      check("R6 hold kept across disable", par_q, mh_a);

      // R4 / R10: clear is immediate, shifts ignored, hold kept
      clr_n = 1'b0;
      #1;
      check("R4 async clear of cascade", {7'd0, ser_out}, 8'd0);
      mc_a = '0; mc_b = '0;
      ser_in = 1'b1;
      strobe(1, 0, 4);
      compare_all("R10 shift ignored in clear");
      check("R4 hold unchanged by clear", par_q, mh_a);
      clr_n = 1'b1;
      wait_edges(2);
      strobe(0, 1, 4);
      m_xfer();
      check("R5 transfer after clear is zero", par_q, 8'h00);
      ser_in = 1'b1;
      strobe(1, 0, 4);
      m_shift(1'b1);
      strobe(0, 1, 4);
      m_xfer();
      check("R10 shift resumes after clear", par_q, 8'h01);

      // R11: 16-bit word through two chained units
      word_v = 16'hC3_5A;
      for (int i = 15; i >= 0; i--) begin
         ser_in = word_v[i];
         strobe(1, 0, 4);
         m_shift(word_v[i]);
      end
      strobe(0, 1, 4);
      m_xfer();
      check("R11 upstream low byte", par_q, 8'h5A);
      check("R11 downstream high byte", par_q_b, 8'hC3);

      // random mix
      for (int n = 0; n < 300; n++) begin
         int unsigned op;
         logic bit_v;
         op = $urandom_range(0, 9);
         bit_v = 1'($urandom_range(0, 1));
         ser_in = bit_v;
         case (op)
            0, 1, 2, 3: begin strobe(1, 0, 4 + $urandom_range(0, 3)); m_shift(bit_v); end
            4, 5:       begin strobe(0, 1, 4); m_xfer(); end
            6:          begin strobe(1, 1, 4); m_xfer(); m_shift(bit_v); end
            7:          begin
                           clr_n = 1'b0;
                           mc_a = '0; mc_b = '0;
                           wait_edges(3);
                           clr_n = 1'b1;
                           wait_edges(1);
                        end
            default:    begin oe_n = ~oe_n; wait_edges(1); end
         endcase
         compare_all("R1 R3 R6 R11 random");
      end
      oe_n = 1'b0;
      wait_edges(1);
      compare_all("R6 final");
      finish_run();
   end
endmodule